// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block sits between five interrupt flags and a processor core and decides which request the core should take next. The sources are two external request flags, two timer overflow flags, and one serial flag that is raised whenever either the receive-done or the transmit-done flag is set. Software sets up one enable register and two priority registers through a small write/read port. The enable register holds a per-source enable and a global enable. One bit from each priority register belongs to each source, and the two bits together give that source one of four preemption levels.

The winning request goes to the core as a registered strobe with a source index. The index stays fixed until the core acknowledges it. On acknowledge, the block marks the winner's level as in service. From then on it passes a new request to the core only if that request's level is strictly above every level in service, which is how service routines nest. A return pulse from the core releases the highest level in service.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset, all three configuration registers read 0x00, `irq_req` is low and `in_svc` is 0.
- R2: `cfg_sel` chooses the register: 0 is the enable register, 1 is the low priority register, 2 is the high priority register, and 3 reads 0 and ignores writes. Enable bit 7 is the global enable and bits 4:0 enable sources 0..4. Bits 6:5 of the enable register and bits 7:5 of both priority registers always read 0, whatever value is written to them.
- R3: A source can win only when its flag is set, its enable bit is set and the global enable is set.
- R4: Source 4 (serial) counts as flagged when `rx_done` or `tx_done` is high.
- R5: The level of source i is {high priority bit i, low priority bit i}, with 0 as the lowest level. The pending source with the highest level is the winner.
- R6: When pending sources share the highest level, the lowest index wins. The indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4.
- R7: `irq_req` and `irq_vec` are registered, so they change one clock after the inputs that cause them. While `irq_req` is high and `irq_ack` is low, both hold their values. `irq_req` goes low on the clock after `irq_ack` is sampled high.
- R8: An acknowledge while `irq_req` is high sets the `in_svc` bit of the presented level. An acknowledge while `irq_req` is low has no effect.
- R9: A winner is presented only if its level is strictly above the highest level in service. Any other winner stays pending and is not presented.
- R10: A `reti` pulse clears only the highest set bit of `in_svc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0 enable, 1 low priority, 2 high priority) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data for the selected register (combinational) |
| hw_flag | input | 4 | Flags: bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1 |
| rx_done | input | 1 | Serial receive-done flag |
| tx_done | input | 1 | Serial transmit-done flag |
| irq_ack | input | 1 | Core acknowledges the presented request |
| reti | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | A request is being presented |
| irq_vec | output | 3 | Index of the presented source, 0..4 |
| in_svc | output | 4 | One bit per level currently in service |

## Verification
The in-service vector is the state that matters most, because every later decision depends on it. If a wrong bit is set, a legitimate higher-level request is either held back or allowed to preempt. If a wrong bit is cleared on return, the damage shows later: a request at an in-service level is presented on the first clock after the bad `reti`. The bench compares `in_svc`, `irq_req` and `irq_vec` against a behavioural model on every clock. A corrupted in-service bit is therefore reported on the cycle after it is written, before any request is misrouted. Mistakes in the winner or the level are reported on the clock where `irq_req` rises.

// File: rtl/intr_prio_pkg.sv
// Package: shared sizes and types for the interrupt priority controller.
// Assumes five sources and four levels; the level width follows from the level count.
package intr_prio_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_LVL  = 4;
    localparam int LVL_W    = $clog2(NUM_LVL);
    localparam int VEC_W    = $clog2(NUM_SRC);
    localparam int CFG_W    = 8;
    localparam int GLB_BIT  = CFG_W - 1;
    localparam int SEL_W    = 2;

    localparam logic [CFG_W-1:0] SRC_MASK = CFG_W'((1 << NUM_SRC) - 1);
    localparam logic [CFG_W-1:0] EN_MASK  = SRC_MASK | CFG_W'(1 << GLB_BIT);

    typedef enum logic [SEL_W-1:0] {
        SEL_ENABLE  = 2'd0,
        SEL_PRIO_LO = 2'd1,
        SEL_PRIO_HI = 2'd2,
        SEL_NONE    = 2'd3
    } cfg_sel_e;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/intr_cfg_regs.sv
// Module: configuration registers (enable, low priority, high priority).
// Masks each write so reserved bits stay zero. Read data is combinational on the select.
module intr_cfg_regs
    import intr_prio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     sel,
    input  logic [CFG_W-1:0]     wdata,
    output logic [CFG_W-1:0]     rdata,
    output logic                 glb_en,
    output logic [NUM_SRC-1:0]   src_en,
    output logic [NUM_SRC-1:0]   prio_lo,
    output logic [NUM_SRC-1:0]   prio_hi
);
    logic [CFG_W-1:0] en_q, lo_q, hi_q;

    // Register writes, with reserved bits masked off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            lo_q <= '0;
            hi_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ENABLE:  en_q <= wdata & EN_MASK;
                SEL_PRIO_LO: lo_q <= wdata & SRC_MASK;
                SEL_PRIO_HI: hi_q <= wdata & SRC_MASK;
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        case (cfg_sel_e'(sel))
            SEL_ENABLE:  rdata = en_q;
            SEL_PRIO_LO: rdata = lo_q;
            SEL_PRIO_HI: rdata = hi_q;
            default:     rdata = '0;
        endcase
    end

    assign glb_en  = en_q[GLB_BIT];
    assign src_en  = en_q[NUM_SRC-1:0];
    assign prio_lo = lo_q[NUM_SRC-1:0];
    assign prio_hi = hi_q[NUM_SRC-1:0];
endmodule

// File: rtl/intr_arbiter.sv
// Module: combinational winner select among pending sources.
// The highest level wins; a tie goes to the lowest index because only a strictly greater level replaces the current best.
module intr_arbiter
    import intr_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0]            pend,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl,
    output logic                          win_valid,
    output vec_t                          win_idx,
    output lvl_t                          win_lvl
);
    // Scan sources in ascending order and keep the best so far.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!win_valid || src_lvl[i] > win_lvl)) begin
                win_valid = 1'b1;
                win_idx   = vec_t'(i);
                win_lvl   = src_lvl[i];
            end
        end
    end
endmodule

// File: rtl/intr_svc_tracker.sv
// Module: in-service level bookkeeping for nesting.
// Sets the acknowledged level and clears the highest set level on return. Reports the top level in service.
module intr_svc_tracker
    import intr_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  lvl_t               set_lvl,
    input  logic               rel,
    output logic [NUM_LVL-1:0] in_svc,
    output logic               any_svc,
    output lvl_t               top_lvl
);
    logic [NUM_LVL-1:0] svc_q, svc_nxt;

    // Find the highest level in service.
    always_comb begin
        top_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (svc_q[l]) top_lvl = lvl_t'(l);
        end
    end

    assign any_svc = |svc_q;

    // Next state: release the top level first, then set the acknowledged one.
    always_comb begin
        svc_nxt = svc_q;
        if (rel && any_svc) svc_nxt[top_lvl] = 1'b0;
        if (set_en)         svc_nxt[set_lvl] = 1'b1;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= '0;
        else        svc_q <= svc_nxt;
    end

    assign in_svc = svc_q;
endmodule

// File: rtl/intr_prio_ctrl.sv
// Module: top of the four-level interrupt priority controller.
// Gates the flags with the enables, arbitrates them, and holds the presented vector until the core acknowledges it.
// Assumes the core clears the source flag inside its service routine.
module intr_prio_ctrl
    import intr_prio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic [NUM_SRC-2:0]   hw_flag,
    input  logic                 rx_done,
    input  logic                 tx_done,
    input  logic                 irq_ack,
    input  logic                 reti,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vec,
    output logic [NUM_LVL-1:0]   in_svc
);
    logic                          glb_en;
    logic [NUM_SRC-1:0]            src_en, prio_lo, prio_hi, src_flag, pend;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic                          win_valid, any_svc, present, ack_take;
    vec_t                          win_idx;
    lvl_t                          win_lvl, top_lvl, pres_lvl_q;
    logic                          req_q;
    vec_t                          vec_q;

    intr_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .glb_en  (glb_en),
        .src_en  (src_en),
        .prio_lo (prio_lo),
        .prio_hi (prio_hi)
    );

    // The serial source combines the receive and transmit flags.
    assign src_flag = {rx_done | tx_done, hw_flag};

    // Build each source's gated request and its two-bit level.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign pend[g]    = src_flag[g] & src_en[g] & glb_en;
        assign src_lvl[g] = {prio_hi[g], prio_lo[g]};
    end

    intr_arbiter u_arb (
        .pend      (pend),
        .src_lvl   (src_lvl),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    // Present the winner only when it is strictly above every level in service.
    assign present  = win_valid && (!any_svc || (win_lvl > top_lvl));
    assign ack_take = req_q && irq_ack;

    // Presentation register: load when idle, hold until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q      <= 1'b0;
            vec_q      <= '0;
            pres_lvl_q <= '0;
        end else if (req_q) begin
            if (irq_ack) req_q <= 1'b0;
        end else if (present) begin
            req_q      <= 1'b1;
            vec_q      <= win_idx;
            pres_lvl_q <= win_lvl;
        end
    end

    intr_svc_tracker u_svc (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ack_take),
        .set_lvl (pres_lvl_q),
        .rel     (reti),
        .in_svc  (in_svc),
        .any_svc (any_svc),
        .top_lvl (top_lvl)
    );

    assign irq_req = req_q;
    assign irq_vec = vec_q;
endmodule

// File: rtl/intr_prio_ctrl_chk.sv
// Module: property checker bound to the controller top.
// Watches the presentation handshake and the in-service vector.
module intr_prio_ctrl_chk
    import intr_prio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               irq_ack,
    input logic               reti,
    input logic [NUM_LVL-1:0] in_svc,
    input lvl_t               pres_lvl_q
);
    // R6: the presented index is always a real source.
    p_vec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) < NUM_SRC));

    // R7: an unacknowledged request holds with the same vector.
    p_vec_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R7: the request drops after acknowledge.
    p_drop_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    // R8: an acknowledge adds exactly one level in service.
    p_ack_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack && !reti) |=>
            ($countones(in_svc) == $countones($past(in_svc)) + 1));

    // R10: a return removes exactly one level in service.
    p_reti_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq_req && irq_ack) && (in_svc != '0)) |=>
            ($countones(in_svc) + 1 == $countones($past(in_svc))));

    // R9: a new request is never at or below a level in service.
    p_preempt_higher_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ((in_svc >> pres_lvl_q) == '0));
endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .irq_vec    (irq_vec),
    .irq_ack    (irq_ack),
    .reti       (reti),
    .in_svc     (in_svc),
    .pres_lvl_q (pres_lvl_q)
);

// File: tb/intr_prio_ctrl_test.sv
// Bench: a behavioural reference model compared every clock, plus directed scenario checks.
module intr_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'd0;
    logic [7:0] cfg_rdata;
    logic [3:0] hw_flag = 4'd0;
    logic       rx_done = 1'b0, tx_done = 1'b0, irq_ack = 1'b0, reti = 1'b0;
    logic       irq_req;
    logic [2:0] irq_vec;
    logic [3:0] in_svc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_flag(hw_flag),
        .rx_done(rx_done), .tx_done(tx_done), .irq_ack(irq_ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .in_svc(in_svc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state.
    int  m_en[5], m_lo[5], m_hi[5];
    int  m_glb, m_vec, m_lvl;
    bit  m_req;
    bit [3:0] m_svc;

    always @(posedge clk) begin
        int best, bl, top, f, lv;
        bit [3:0] nsvc;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
            m_glb = 0; m_req = 0; m_vec = 0; m_lvl = 0; m_svc = 0;
        end else begin
            best = -1; bl = -1;
            for (int i = 0; i < 5; i++) begin
                f = (i < 4) ? int'(hw_flag[i]) : int'(rx_done || tx_done);
                lv = m_hi[i] * 2 + m_lo[i];
                if (f != 0 && m_glb != 0 && m_en[i] != 0 && lv > bl) begin best = i; bl = lv; end
            end
            top = -1;
            for (int l = 0; l < 4; l++) if (m_svc[l]) top = l;
            nsvc = m_svc;
            if (reti && top >= 0) nsvc[top] = 1'b0;
            if (irq_ack && m_req) nsvc[m_lvl] = 1'b1;
            if (m_req) begin
                if (irq_ack) m_req = 0;
            end else if (best >= 0 && bl > top) begin
                m_req = 1; m_vec = best; m_lvl = bl;
            end
            m_svc = nsvc;
            if (cfg_we) begin
                for (int i = 0; i < 5; i++) begin
                    if (cfg_sel == 2'd0) m_en[i] = int'(cfg_wdata[i]);
                    if (cfg_sel == 2'd1) m_lo[i] = int'(cfg_wdata[i]);
                    if (cfg_sel == 2'd2) m_hi[i] = int'(cfg_wdata[i]);
                end
                if (cfg_sel == 2'd0) m_glb = int'(cfg_wdata[7]);
            end
        end
    end

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_req == m_req, "R7 request strobe", int'(irq_req), int'(m_req));
            if (m_req) chk(int'(irq_vec) == m_vec, "R6 vector index", int'(irq_vec), m_vec);
            chk(in_svc == m_svc, "R8 in-service vector", int'(in_svc), int'(m_svc));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input int exp, input string tag);
        cfg_sel = s; #1;
        chk(int'(cfg_rdata) == exp, tag, int'(cfg_rdata), exp);
    endtask

    task automatic ack();
        irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1; cyc(1); reti = 1'b0;
    endtask

    task automatic expect_req(input int vec, input string tag);
        #1;
        chk(irq_req == 1'b1, tag, int'(irq_req), 1);
        chk(int'(irq_vec) == vec, tag, int'(irq_vec), vec);
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(irq_req == 1'b0, "R1 reset request", int'(irq_req), 0);
        chk(in_svc == 4'd0, "R1 reset in-service", int'(in_svc), 0);
        rd_chk(2'd0, 0, "R1 reset enable reg");
        rd_chk(2'd1, 0, "R1 reset low prio reg");
        rd_chk(2'd2, 0, "R1 reset high prio reg");

        // R2 reserved bits and select decode
        wr(2'd0, 8'hFF); rd_chk(2'd0, 8'h9F, "R2 enable reserved bits");
        wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h1F, "R2 low prio reserved bits");
        wr(2'd2, 8'hE0); rd_chk(2'd2, 8'h00, "R2 high prio reserved bits");
        wr(2'd3, 8'hFF); rd_chk(2'd3, 0, "R2 unused select");
        wr(2'd1, 8'h00);

        // R3 global enable gating
        wr(2'd0, 8'h1F);
        hw_flag = 4'b0001;
        cyc(3); #1;
        chk(irq_req == 1'b0, "R3 global enable off", int'(irq_req), 0);
        wr(2'd0, 8'h9E);
        cyc(2); #1;
        chk(irq_req == 1'b0, "R3 source enable off", int'(irq_req), 0);
        wr(2'd0, 8'h9F);
        cyc(1);
        expect_req(0, "R3 all enables set");
        hw_flag = 4'b0000;
        ack();
        #1;
        chk(irq_req == 1'b0, "R7 drop after ack", int'(irq_req), 0);
        chk(in_svc == 4'b0001, "R8 level 0 in service", int'(in_svc), 1);
        ret(); #1;
        chk(in_svc == 4'b0000, "R10 return clears level 0", int'(in_svc), 0);

        // R4 serial from receive-done only
        rx_done = 1'b1;
        cyc(2);
        expect_req(4, "R4 serial via receive");
        rx_done = 1'b0;
        ack(); ret();

        // R5 highest level wins: timer 1 at level 3 against external 0 at level 0
        wr(2'd1, 8'h08); wr(2'd2, 8'h08);
        hw_flag = 4'b1001;
        cyc(2);
        expect_req(3, "R5 highest level wins");
        hw_flag = 4'b0001;
        ack();
        cyc(2); #1;
        chk(irq_req == 1'b0, "R9 lower level held back", int'(irq_req), 0);
        ret();
        cyc(1);
        expect_req(0, "R10 pending level 0 after return");
        hw_flag = 4'b0000;
        ack(); ret();

        // R6 tie at level 2 between timer 0 and external 1
        wr(2'd1, 8'h00); wr(2'd2, 8'h06);
        hw_flag = 4'b0110;
        cyc(2);
        expect_req(1, "R6 tie goes to lower index");
        hw_flag = 4'b0100;
        ack();
        cyc(2); #1;
        chk(irq_req == 1'b0, "R9 same level held back", int'(irq_req), 0);
        ret();
        cyc(1);
        expect_req(2, "R6 remaining tied source");
        hw_flag = 4'b0000;
        ack(); ret();

        // R9/R10 nesting: ext0 and tmr0 at level 1, tmr1 at level 2
        wr(2'd1, 8'h03); wr(2'd2, 8'h08);
        hw_flag = 4'b0001;
        cyc(2);
        expect_req(0, "R9 first level 1 request");
        hw_flag = 4'b0000;
        ack();
        hw_flag = 4'b0010;
        cyc(3); #1;
        chk(irq_req == 1'b0, "R9 equal level not presented", int'(irq_req), 0);
        hw_flag = 4'b1010;
        cyc(1);
        expect_req(3, "R9 higher level preempts");
        hw_flag = 4'b0010;
        ack(); #1;
        chk(in_svc == 4'b0110, "R8 nested levels in service", int'(in_svc), 6);
        ret(); #1;
        chk(in_svc == 4'b0010, "R10 only top level cleared", int'(in_svc), 2);
        cyc(2); #1;
        chk(irq_req == 1'b0, "R9 still blocked by level 1", int'(irq_req), 0);
        ret();
        cyc(1);
        expect_req(1, "R10 blocked source released");
        hw_flag = 4'b0000;
        ack(); ret();

        // R7 vector held while a higher source arrives; R4 via transmit-done
        wr(2'd1, 8'h00); wr(2'd2, 8'h00);
        hw_flag = 4'b0001;
        cyc(2);
        expect_req(0, "R7 low request presented");
        wr(2'd2, 8'h10);
        tx_done = 1'b1;
        cyc(3);
        expect_req(0, "R7 vector stable until ack");
        hw_flag = 4'b0000;
        ack();
        cyc(1);
        expect_req(4, "R4 serial via transmit preempts");
        tx_done = 1'b0;
        ack(); #1;
        chk(in_svc == 4'b0101, "R8 levels 0 and 2 in service", int'(in_svc), 5);
        ret(); ret(); #1;
        chk(in_svc == 4'b0000, "R10 all released", int'(in_svc), 0);

        // R8 stray acknowledge is ignored
        ack(); #1;
        chk(in_svc == 4'b0000, "R8 ack without request ignored", int'(in_svc), 0);

        cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule